// File: doc/BRIEF.md
# Privilege-Gated Cycle Timestamp Counter

This block holds a free-running cycle counter and answers timestamp read requests from an instruction pipeline. The counter advances by one on every clock and returns to zero on reset. Each read request carries the requester's privilege level, a timestamp-disable control bit, a secure-interval status bit and an environment select. A permitted read returns the count as an upper and a lower 32-bit word. A refused read returns a general-protection fault whose error code is zero, and it returns no count.

A second port stands for a model-specific-register read. It returns the full count with no timestamp-disable check, because the privilege rules for that path are enforced elsewhere. Both ports answer one cycle after the request. The answer carries the count as it stood in the request cycle. When the count passes all ones it wraps to zero and gives no overflow indication.

Top module: `tsc_timestamp_unit`

## Requirements
- R1: While `rst_n` is low the count is forced to 0 and neither port gives a response. A read requested in the first cycle after reset is released returns 0.
- R2: The count rises by exactly one on every clock cycle out of reset, so reads in consecutive cycles return values that differ by 1.
- R3: A permitted read returns count bits [63:32] on `rd_hi` and bits [31:0] on `rd_lo`, with `rd_fault` at 0.
- R4: In the legacy environment (`rd_ext_mode`=0), a read is permitted at any privilege when `rd_tsd`=0. When `rd_tsd`=1 it is permitted only when `rd_priv`=0.
- R5: In the extended environment (`rd_ext_mode`=1), the secured condition is `rd_tsd` OR `rd_si`. A read is permitted at any privilege when the condition is 0, and only at `rd_priv`=0 when it is 1.
- R6: A refused read responds with `rd_fault`=1 and `rd_err_code`=0, and drives both data words to 0.
- R7: Every read request produces exactly one response cycle, with `rd_valid` high, in the cycle after the request. `rd_valid` is low in every other cycle.
- R8: A `msr_req` pulse gives `msr_valid` in the next cycle with `msr_data` equal to the full 64-bit count of the request cycle. This holds whatever the values of `rd_priv`, `rd_tsd`, `rd_si` and `rd_ext_mode`.
- R9: In the legacy environment `rd_si` has no effect on whether a read is permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Single-cycle timestamp read request |
| rd_priv | input | 2 | Privilege level of the requester, 0 most privileged |
| rd_tsd | input | 1 | Timestamp-disable control |
| rd_si | input | 1 | Secure-interval status |
| rd_ext_mode | input | 1 | 0 legacy environment, 1 extended environment |
| rd_valid | output | 1 | Read response valid |
| rd_fault | output | 1 | Response is a general-protection fault |
| rd_err_code | output | 16 | Fault error code, always 0 |
| rd_hi | output | 32 | Upper word of the count |
| rd_lo | output | 32 | Lower word of the count |
| msr_req | input | 1 | Single-cycle register-port read request |
| msr_valid | output | 1 | Register-port response valid |
| msr_data | output | 64 | Full count from the register port |

## Verification
The access check is driven over every combination of privilege, disable bit, secure bit and environment. This separates the legacy gate, which ignores the secure bit, from the extended gate, which ORs it in, and it separates privilege 0 from the three less privileged levels. Random gaps and back-to-back requests show whether each response is one cycle late and carries the count of the request cycle. Register-port reads issued alongside refused timestamp reads show that the gate does not reach that path. A read in the first cycle after reset checks the cleared start value.

// File: rtl/tsc_pkg.sv
// Shared types for the timestamp unit.
// Assumes a 2-bit privilege level in which 0 is the most privileged.
package tsc_pkg;
    localparam int PRIV_W = 2;

    typedef enum logic {
        ENV_LEGACY = 1'b0,
        ENV_EXT    = 1'b1
    } env_e;

    typedef struct packed {
        logic [PRIV_W-1:0] priv;
        logic              tsd;
        logic              si;
        env_e              env;
    } rd_ctl_t;
endpackage

// File: rtl/tsc_counter.sv
// Free-running cycle counter. It clears on synchronous active-low reset and
// wraps silently at all ones. Assumes nothing ever writes it.
module tsc_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;

    // Advance by one each cycle, or clear when in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tsc_gate.sv
// Combinational access check for a timestamp read. Assumes the control
// fields are already valid in the request cycle.
module tsc_gate
    import tsc_pkg::*;
(
    input  rd_ctl_t ctl,
    output logic    grant
);
    logic secured;

    // Form the secured condition for the selected environment, then apply the privilege rule.
    always_comb begin
        if (ctl.env == ENV_EXT) secured = ctl.tsd | ctl.si;
        else                    secured = ctl.tsd;
        grant = !secured || (ctl.priv == '0);
    end
endmodule

// File: rtl/tsc_resp.sv
// Registered response stage for one read port. The response carries the count
// sampled in the request cycle. With GATED=1 it applies the grant and reports
// a fault on refusal; with GATED=0 it always returns data.
module tsc_resp #(
    parameter int CNT_W  = 64,
    parameter int ERR_W  = 16,
    parameter bit GATED  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             grant,
    input  logic [CNT_W-1:0] count,
    output logic             valid,
    output logic             fault,
    output logic [ERR_W-1:0] err_code,
    output logic [CNT_W-1:0] data
);
    logic ok;

    generate
        if (GATED) begin : g_gated
            assign ok = grant;
        end else begin : g_open
            assign ok = 1'b1;
        end
    endgenerate

    // Capture a response for each request; refused reads return a fault and no data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            fault <= 1'b0;
            data  <= '0;
        end else begin
            valid <= req;
            fault <= req && !ok;
            data  <= (req && ok) ? count : '0;
        end
    end

    assign err_code = '0;

    a_r7_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid);

    a_r6_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (valid && data == '0 && err_code == '0));
endmodule

// File: rtl/tsc_timestamp_unit.sv
// Top level of the timestamp unit: one counter, a privilege-gated read port
// and an ungated register-style read port. Assumes requests are one-cycle pulses.
module tsc_timestamp_unit
    import tsc_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int ERR_W = 16,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [PRIV_W-1:0] rd_priv,
    input  logic              rd_tsd,
    input  logic              rd_si,
    input  logic              rd_ext_mode,
    output logic              rd_valid,
    output logic              rd_fault,
    output logic [ERR_W-1:0]  rd_err_code,
    output logic [HALF_W-1:0] rd_hi,
    output logic [HALF_W-1:0] rd_lo,
    input  logic              msr_req,
    output logic              msr_valid,
    output logic [CNT_W-1:0]  msr_data
);
    logic [CNT_W-1:0] count;
    logic             grant;
    rd_ctl_t          ctl;
    logic [CNT_W-1:0] rd_word;
    logic             msr_fault_unused;
    logic [ERR_W-1:0] msr_err_unused;

    // Bundle the request controls for the gate.
    always_comb begin
        ctl.priv = rd_priv;
        ctl.tsd  = rd_tsd;
        ctl.si   = rd_si;
        ctl.env  = env_e'(rd_ext_mode);
    end

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    tsc_gate u_gate (
        .ctl   (ctl),
        .grant (grant)
    );

    tsc_resp #(.CNT_W(CNT_W), .ERR_W(ERR_W), .GATED(1'b1)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .grant    (grant),
        .count    (count),
        .valid    (rd_valid),
        .fault    (rd_fault),
        .err_code (rd_err_code),
        .data     (rd_word)
    );

    tsc_resp #(.CNT_W(CNT_W), .ERR_W(ERR_W), .GATED(1'b0)) u_msr (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (msr_req),
        .grant    (1'b1),
        .count    (count),
        .valid    (msr_valid),
        .fault    (msr_fault_unused),
        .err_code (msr_err_unused),
        .data     (msr_data)
    );

    assign rd_hi = rd_word[CNT_W-1:HALF_W];
    assign rd_lo = rd_word[HALF_W-1:0];

    a_r4_legacy_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ext_mode && rd_tsd && rd_priv != '0) |=> (rd_valid && rd_fault));

    a_r9_legacy_si_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ext_mode && !rd_tsd) |=> (rd_valid && !rd_fault));

    a_r5_ext_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ext_mode && (rd_tsd || rd_si) && rd_priv != '0) |=> (rd_valid && rd_fault));

    a_r3_grant_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_priv == '0) |=> (!rd_fault && {rd_hi, rd_lo} == $past(count)));

    a_r8_msr_data: assert property (@(posedge clk) disable iff (!rst_n)
        msr_req |=> (msr_valid && msr_data == $past(count)));
endmodule

// File: tb/tb_tsc_timestamp_unit.sv
module tb_tsc_timestamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_priv = '0;
    logic        rd_tsd = 1'b0;
    logic        rd_si = 1'b0;
    logic        rd_ext_mode = 1'b0;
    logic        rd_valid, rd_fault;
    logic [15:0] rd_err_code;
    logic [31:0] rd_hi, rd_lo;
    logic        msr_req = 1'b0;
    logic        msr_valid;
    logic [63:0] msr_data;

    int checks = 0;
    int errors = 0;
    logic [63:0] mcnt;

    tsc_timestamp_unit dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_priv(rd_priv),
        .rd_tsd(rd_tsd), .rd_si(rd_si), .rd_ext_mode(rd_ext_mode),
        .rd_valid(rd_valid), .rd_fault(rd_fault), .rd_err_code(rd_err_code),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .msr_req(msr_req),
        .msr_valid(msr_valid), .msr_data(msr_data)
    );

    always #10 clk = ~clk;

    // Reference cycle count (R1, R2)
    always @(posedge clk) mcnt <= !rst_n ? 64'd0 : mcnt + 64'd1;

    function automatic logic exp_grant(logic [1:0] p, logic t, logic s, logic e);
        logic sec;
        sec = e ? (t | s) : t;
        return !sec || (p == 2'd0);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Previous-cycle request state for checking at the next negedge
    logic        p_rd, p_msr, p_gr;
    logic [63:0] p_cnt;
    string       p_tag;

    task automatic check_prev();
        chk({p_tag, " R7 rd_valid"}, {63'd0, rd_valid}, {63'd0, p_rd});
        chk("R8 msr_valid", {63'd0, msr_valid}, {63'd0, p_msr});
        if (p_msr) chk("R8 msr_data", msr_data, p_cnt);
        if (p_rd) begin
            chk({p_tag, " rd_fault"}, {63'd0, rd_fault}, {63'd0, !p_gr});
            if (p_gr) chk("R3 rd_hi:rd_lo", {rd_hi, rd_lo}, p_cnt);
            else begin
                chk("R6 data zero", {rd_hi, rd_lo}, 64'd0);
                chk("R6 err code", {48'd0, rd_err_code}, 64'd0);
            end
        end
    endtask

    task automatic drive(logic r, logic [1:0] p, logic t, logic s, logic e, logic m, string tag);
        rd_req = r; rd_priv = p; rd_tsd = t; rd_si = s; rd_ext_mode = e; msr_req = m;
        p_rd = r; p_msr = m; p_gr = exp_grant(p, t, s, e); p_cnt = mcnt;
        p_tag = tag;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] first;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rd_req = 1'b1; msr_req = 1'b1;
        @(negedge clk);
        chk("R1 no rd_valid in reset", {63'd0, rd_valid}, 64'd0);
        chk("R1 no msr_valid in reset", {63'd0, msr_valid}, 64'd0);
        // Release reset and read in the same cycle
        rst_n = 1'b1;
        drive(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        @(negedge clk);
        chk("R1 first read zero", {rd_hi, rd_lo}, 64'd0);
        chk("R1 first msr zero", msr_data, 64'd0);
        check_prev();
        // Back-to-back reads (R2)
        drive(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        @(negedge clk);
        first = {rd_hi, rd_lo};
        check_prev();
        drive(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        @(negedge clk);
        chk("R2 consecutive step", {rd_hi, rd_lo} - first, 64'd1);
        check_prev();
        // Exhaustive control combinations (R4, R5, R9), with register reads alongside (R8)
        for (int i = 0; i < 32; i++) begin
            drive(1'b1, i[1:0], i[2], i[3], i[4], 1'b1, i[4] ? "R5" : "R4 R9");
            @(negedge clk);
            check_prev();
        end
        // Directed: legacy with secure bit set, low privilege (R9)
        drive(1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        @(negedge clk);
        chk("R9 legacy si ignored", {63'd0, rd_fault}, 64'd0);
        check_prev();
        // Random traffic with gaps
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0] & r[1], r[3:2], r[4], r[5], r[6], r[7] & r[8], r[6] ? "R5" : "R4");
            @(negedge clk);
            check_prev();
        end
        drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        @(negedge clk);
        check_prev();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule